// File: doc/BRIEF.md
# H-Bridge Command and Fault Supervisor

This block sits between a pair of already-synchronised direction commands and the gate drivers of a single H-bridge. It turns the two command bits into on/off enables for the high-side and low-side switch of each leg. A change between two driving patterns passes through a short all-off gap, so no leg ever conducts from supply to ground. When both commands are low, the block parks the bridge in a low-power idle state with both legs floating. It also raises a one-cycle request to the downstream duty regulator whenever a forward or reverse drive begins, so that the regulator can restart from zero duty.

Protection events arrive as digital flags. Supply undervoltage resets the whole supervisor. A sustained overcurrent latches a shutdown that only a power cycle (undervoltage or reset) releases. Over-temperature blocks the bridge only while the flag is present. A persisting current-limit condition reports a fault while the bridge keeps running. All of these, plus a fixed-width pulse on every exit from idle, drive a single active-low fault output.

Top module: `hbridge_supervisor`

## Requirements
- R1: After reset with both commands low, all four enables are 0, both `leg_hiz` bits are 1, `sleep_o` is 1, `ramp_start` is 0 and `fault_n` is 1.
- R2: The command pair {cmd_a,cmd_b} selects the drive pattern, with bit 0 of each enable vector for leg A (OUT1) and bit 1 for leg B (OUT2). 10 gives forward (hs_en=01, ls_en=10), 01 gives reverse (hs_en=10, ls_en=01), 11 gives brake (hs_en=11, ls_en=00) and 00 gives all off with leg_hiz=11. From the all-off state, a new pattern appears one clock after the command.
- R3: A change from one driving pattern (forward, reverse or brake) to a different one holds all four enables at 0 for exactly DEAD_CYC cycles before the new pattern appears. A leg's high-side and low-side enables are never 1 together and never follow one another in adjacent cycles.
- R4: `sleep_o` is 1 one clock after the commands are sampled as 00 and 0 one clock after either command is sampled high. While `sleep_o` is 1, all enables are 0.
- R5: Leaving idle (`sleep_o` falling) drives `fault_n` low for exactly WAKE_PULSE_CYC cycles, starting in the same cycle in which `sleep_o` falls.
- R6: `ramp_start` is 1 for one cycle, the first cycle in which a forward or reverse pattern is applied after any other state (idle, brake, dead gap, the opposite direction or a protection block). It is 0 in every other cycle.
- R7: `ocp_flag` sampled high on OCP_DEGLITCH_CYC consecutive clocks latches a shutdown. From that clock on, all enables are 0 and `fault_n` is 0, whatever the commands or the flag later do, until `rst_n` or `uvlo_flag` resets the block. A shorter burst has no effect.
- R8: While `otemp_flag` is 1, all enables are 0 and `fault_n` is 0 in the same cycle. The first clock after the flag clears applies the commanded pattern as if from idle.
- R9: While `uvlo_flag` is 1, all enables are 0 and `fault_n` is 0. Every internal state returns to its reset value, including a latched overcurrent shutdown. After release, the block behaves as it does after reset.
- R10: `ilim_flag` sampled high on ILIM_PERSIST_CYC consecutive clocks drives `fault_n` low without changing the enables. The fault clears on the first clock at which the flag is sampled low.
- R11: Sampling the commands as 00 clears a pending current-limit fault and restarts its persistence count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_a | input | 1 | Direction command, high drives leg A high |
| cmd_b | input | 1 | Direction command, high drives leg B high |
| ocp_flag | input | 1 | Raw overcurrent indication |
| otemp_flag | input | 1 | Over-temperature indication |
| uvlo_flag | input | 1 | Supply below lockout threshold |
| ilim_flag | input | 1 | Current-limit regulation active |
| hs_en | output | 2 | High-side switch enables, bit 0 leg A, bit 1 leg B |
| ls_en | output | 2 | Low-side switch enables, bit 0 leg A, bit 1 leg B |
| leg_hiz | output | 2 | Leg floating (both switches off) |
| sleep_o | output | 1 | Idle/low-power state |
| ramp_start | output | 1 | Request for the duty regulator to restart from zero |
| fault_n | output | 1 | Active-low combined fault |

## Verification
A wrong drive-mode register or dead-gap counter shows at the enables within one clock of a command change. It appears either as a leg driven both ways in adjacent cycles or as a gap shorter or longer than DEAD_CYC. A wrong idle register shows at once as a missing or misplaced fault pulse. A persistence counter off by one moves the fault edge by one cycle at the boundary, so each burst length is checked exactly at the threshold and one cycle below it. A lost overcurrent latch shows as the bridge re-driving after a later command change.

// File: rtl/hb_pkg.sv
// Shared drive-mode type and pattern decode for the H-bridge supervisor.
// Assumes two legs; bit 0 of every per-leg vector is leg A (OUT1).
package hb_pkg;

    localparam int unsigned LEGS = 2;

    // Encoding equals the command pair {cmd_a, cmd_b}.
    typedef enum logic [1:0] {
        DRV_COAST = 2'b00,
        DRV_REV   = 2'b01,
        DRV_FWD   = 2'b10,
        DRV_BRAKE = 2'b11
    } drv_mode_t;

    // True for the two modes that push current through the load.
    function automatic logic is_run(drv_mode_t m);
        return (m == DRV_FWD) || (m == DRV_REV);
    endfunction

    // High-side enables: a leg goes high when its own command bit is set.
    function automatic logic [LEGS-1:0] hs_of(drv_mode_t m);
        return {m[0], m[1]};
    endfunction

    // Low-side enables: a leg goes low only when the other leg is high alone.
    function automatic logic [LEGS-1:0] ls_of(drv_mode_t m);
        return {m == DRV_FWD, m == DRV_REV};
    endfunction

endpackage

// File: rtl/hb_persist_filter.sv
// Persistence filter: asserts hit after evt is sampled high on LIMIT
// consecutive clocks. STICKY=1 keeps hit until reset; STICKY=0 drops it
// when evt is sampled low. clr restarts the count and drops hit.
// Assumes LIMIT >= 1 and a synchronous active-low reset.
module hb_persist_filter #(
    parameter int unsigned LIMIT  = 4,
    parameter bit          STICKY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic hit
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          hit_q;
    logic          may_release;

    // Variant select: latched events never release on their own.
    generate
        if (STICKY) begin : g_latch
            assign may_release = 1'b0;
        end else begin : g_follow
            assign may_release = 1'b1;
        end
    endgenerate

    // Count consecutive event cycles and set/release the hit flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            hit_q <= 1'b0;
        end else if (evt) begin
            if (!hit_q) begin
                if (cnt_q == LAST) hit_q <= 1'b1;
                else               cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
            if (may_release) hit_q <= 1'b0;
        end
    end

    assign hit = hit_q;
endmodule

// File: rtl/hb_wake_pulse.sv
// Idle tracker and wake pulse: asleep follows the idle request one clock
// late; leaving idle starts a pulse of exactly PULSE_CYC cycles.
// Reset value is asleep, so a first non-idle command also pulses.
module hb_wake_pulse #(
    parameter int unsigned PULSE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_req,
    output logic asleep,
    output logic pulse
);
    localparam int unsigned PW = $clog2(PULSE_CYC + 1);

    logic          sleep_q;
    logic [PW-1:0] left_q;

    // Track the idle state and time the wake pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep_q <= 1'b1;
            left_q  <= '0;
        end else begin
            sleep_q <= idle_req;
            if (sleep_q && !idle_req) left_q <= PW'(PULSE_CYC);
            else if (left_q != '0)    left_q <= left_q - 1'b1;
        end
    end

    assign asleep = sleep_q;
    assign pulse  = (left_q != '0);
endmodule

// File: rtl/hb_bridge_seq.sv
// Bridge sequencer: applies the requested drive mode, inserting DEAD_CYC
// all-off cycles between two different driving patterns, and flags the
// start of each forward/reverse drive. block forces all switches off
// immediately and parks the applied mode at coast. Assumes DEAD_CYC >= 1.
module hb_bridge_seq
    import hb_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  drv_mode_t       req,
    input  logic            block,
    output logic [LEGS-1:0] hs_en,
    output logic [LEGS-1:0] ls_en,
    output logic            ramp_start
);
    localparam int unsigned GW = $clog2(DEAD_CYC + 1);
    localparam logic [GW-1:0] GAP_LOAD = GW'(DEAD_CYC);
    localparam logic [GW-1:0] GAP_LAST = GW'(1);

    drv_mode_t     drv_q, drv_d;
    logic [GW-1:0] gap_q, gap_d;
    logic          ramp_q;
    logic [LEGS-1:0] hs_raw, ls_raw;

    // Next applied mode and dead-gap count.
    always_comb begin
        drv_d = drv_q;
        gap_d = gap_q;
        if (block) begin
            drv_d = DRV_COAST;
            gap_d = '0;
        end else if (gap_q != '0) begin
            gap_d = gap_q - 1'b1;
            if (gap_q == GAP_LAST) drv_d = req;
        end else if (req != drv_q) begin
            if (drv_q == DRV_COAST || req == DRV_COAST) begin
                drv_d = req;
            end else begin
                drv_d = DRV_COAST;
                gap_d = GAP_LOAD;
            end
        end
    end

    // Register the applied mode, the gap and the ramp request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q  <= DRV_COAST;
            gap_q  <= '0;
            ramp_q <= 1'b0;
        end else begin
            drv_q  <= drv_d;
            gap_q  <= gap_d;
            ramp_q <= is_run(drv_d) && (drv_d != drv_q);
        end
    end

    assign hs_raw = hs_of(drv_q);
    assign ls_raw = ls_of(drv_q);

    // Per-leg gating of the decoded pattern by the protection block.
    generate
        for (genvar g = 0; g < LEGS; g++) begin : g_leg
            assign hs_en[g] = hs_raw[g] & ~block;
            assign ls_en[g] = ls_raw[g] & ~block;
        end
    endgenerate

    assign ramp_start = ramp_q & ~block;
endmodule

// File: rtl/hbridge_supervisor.sv
// H-bridge command and fault supervisor. Decodes the command pair into
// switch enables, handles idle entry/exit and merges protection events
// into one active-low fault. Priority: undervoltage (resets everything),
// latched overcurrent, over-temperature, then normal decode.
// Assumes cmd_* and all flags are already synchronous to clk.
module hbridge_supervisor
    import hb_pkg::*;
#(
    parameter int unsigned DEAD_CYC         = 4,
    parameter int unsigned WAKE_PULSE_CYC   = 125,
    parameter int unsigned OCP_DEGLITCH_CYC = 250,
    parameter int unsigned ILIM_PERSIST_CYC = 34375000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_a,
    input  logic            cmd_b,
    input  logic            ocp_flag,
    input  logic            otemp_flag,
    input  logic            uvlo_flag,
    input  logic            ilim_flag,
    output logic [LEGS-1:0] hs_en,
    output logic [LEGS-1:0] ls_en,
    output logic [LEGS-1:0] leg_hiz,
    output logic            sleep_o,
    output logic            ramp_start,
    output logic            fault_n
);
    drv_mode_t req;
    logic      core_rst_n;
    logic      ocp_latched;
    logic      ilim_active;
    logic      wake_pulse;
    logic      block;
    logic      idle_req;

    assign req        = drv_mode_t'({cmd_a, cmd_b});
    assign idle_req   = (req == DRV_COAST);
    assign core_rst_n = rst_n & ~uvlo_flag;
    assign block      = uvlo_flag | ocp_latched | otemp_flag;

    // Overcurrent: deglitched, then latched until a power cycle.
    hb_persist_filter #(
        .LIMIT  (OCP_DEGLITCH_CYC),
        .STICKY (1'b1)
    ) ocp_filt_i (
        .clk   (clk),
        .rst_n (core_rst_n),
        .evt   (ocp_flag),
        .clr   (1'b0),
        .hit   (ocp_latched)
    );

    // Current limit: persistence fault, self-clearing, cleared by idle.
    hb_persist_filter #(
        .LIMIT  (ILIM_PERSIST_CYC),
        .STICKY (1'b0)
    ) ilim_filt_i (
        .clk   (clk),
        .rst_n (core_rst_n),
        .evt   (ilim_flag),
        .clr   (idle_req),
        .hit   (ilim_active)
    );

    hb_wake_pulse #(
        .PULSE_CYC (WAKE_PULSE_CYC)
    ) wake_i (
        .clk      (clk),
        .rst_n    (core_rst_n),
        .idle_req (idle_req),
        .asleep   (sleep_o),
        .pulse    (wake_pulse)
    );

    hb_bridge_seq #(
        .DEAD_CYC (DEAD_CYC)
    ) seq_i (
        .clk        (clk),
        .rst_n      (core_rst_n),
        .req        (req),
        .block      (block),
        .hs_en      (hs_en),
        .ls_en      (ls_en),
        .ramp_start (ramp_start)
    );

    // Floating-leg indication per leg.
    generate
        for (genvar g = 0; g < LEGS; g++) begin : g_hiz
            assign leg_hiz[g] = ~(hs_en[g] | ls_en[g]);
        end
    endgenerate

    assign fault_n = ~(uvlo_flag | ocp_latched | otemp_flag | ilim_active | wake_pulse);
endmodule

// File: rtl/hbridge_supervisor_chk.sv
// Property checker for hbridge_supervisor, attached with bind.
// Watches ports plus the latched overcurrent and current-limit states.
module hbridge_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       uvlo_flag,
    input logic       otemp_flag,
    input logic [1:0] hs_en,
    input logic [1:0] ls_en,
    input logic       sleep_o,
    input logic       ramp_start,
    input logic       fault_n,
    input logic       ocp_latched,
    input logic       ilim_active
);
    // R3
    shoot_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hs_en & ls_en) == 2'b00));
    // R3
    leg_a_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en[0] |=> !ls_en[0]) and (ls_en[0] |=> !hs_en[0]));
    // R3
    leg_b_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en[1] |=> !ls_en[1]) and (ls_en[1] |=> !hs_en[1]));
    // R4
    sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> (hs_en == 2'b00 && ls_en == 2'b00));
    // R5
    wake_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_o) |-> !fault_n);
    // R6
    ramp_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_start |-> ((hs_en ^ ls_en) == 2'b11 && $countones(hs_en) == 1
                        && !$stable({hs_en, ls_en})));
    // R7
    ocp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ocp_latched && !uvlo_flag) |=> ocp_latched);
    // R7
    ocp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ocp_latched |-> (hs_en == 2'b00 && ls_en == 2'b00 && !fault_n));
    // R8
    otemp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        otemp_flag |-> (hs_en == 2'b00 && ls_en == 2'b00 && !fault_n));
    // R9
    uvlo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_flag |-> (hs_en == 2'b00 && ls_en == 2'b00 && !fault_n));
    // R10
    ilim_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_active |-> !fault_n);
endmodule

bind hbridge_supervisor hbridge_supervisor_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .uvlo_flag   (uvlo_flag),
    .otemp_flag  (otemp_flag),
    .hs_en       (hs_en),
    .ls_en       (ls_en),
    .sleep_o     (sleep_o),
    .ramp_start  (ramp_start),
    .fault_n     (fault_n),
    .ocp_latched (ocp_latched),
    .ilim_active (ilim_active)
);

// File: tb/hbridge_supervisor_tb_top.sv
`timescale 1ns/1ps
module hbridge_supervisor_tb_top;
    localparam int DEAD  = 3;
    localparam int PULSE = 5;
    localparam int OCPN  = 4;
    localparam int ILIMN = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_a = 1'b0, cmd_b = 1'b0;
    logic ocp = 1'b0, otemp = 1'b0, uvlo = 1'b0, ilim = 1'b0;
    logic [1:0] hs_en, ls_en, leg_hiz;
    logic sleep_o, ramp_start, fault_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hbridge_supervisor #(
        .DEAD_CYC(DEAD), .WAKE_PULSE_CYC(PULSE),
        .OCP_DEGLITCH_CYC(OCPN), .ILIM_PERSIST_CYC(ILIMN)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_a(cmd_a), .cmd_b(cmd_b),
        .ocp_flag(ocp), .otemp_flag(otemp), .uvlo_flag(uvlo), .ilim_flag(ilim),
        .hs_en(hs_en), .ls_en(ls_en), .leg_hiz(leg_hiz), .sleep_o(sleep_o),
        .ramp_start(ramp_start), .fault_n(fault_n)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected enables per mode {a,b}; bit 0 = leg A.
    function automatic logic [1:0] exp_hs(int m);
        case (m) 2: return 2'b01; 1: return 2'b10; 3: return 2'b11; default: return 2'b00; endcase
    endfunction
    function automatic logic [1:0] exp_ls(int m);
        case (m) 2: return 2'b10; 1: return 2'b01; default: return 2'b00; endcase
    endfunction

    task automatic set_cmd(int m);
        cmd_a = m[1];
        cmd_b = m[0];
    endtask

    task automatic settle(int m, int n);
        set_cmd(m);
        repeat (n) tick();
    endtask

    task automatic expect_drive(int m, string tag);
        check(hs_en == exp_hs(m) && ls_en == exp_ls(m), tag,
              {4'h0, hs_en, ls_en}, {4'h0, exp_hs(m), exp_ls(m)});
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check({hs_en, ls_en, leg_hiz, sleep_o, ramp_start, fault_n} == 9'b0000_11_1_0_1,
              "R1 reset state", {hs_en, ls_en, leg_hiz[1:0]}, 8'h03);

        // R2/R3/R6 sweep over all mode-to-mode transitions
        for (int f = 0; f < 4; f++) begin
            for (int t = 0; t < 4; t++) begin
                bit swap;
                swap = (f != 0) && (t != 0) && (f != t);
                settle(0, 3);
                settle(f, DEAD + PULSE + 3);
                set_cmd(t);
                for (int k = 1; k <= DEAD + 2; k++) begin
                    int cur;
                    bit rexp;
                    tick();
                    cur  = (swap && k <= DEAD) ? 0 : t;
                    rexp = (t == 1 || t == 2) && (f != t) && (k == (swap ? DEAD + 1 : 1));
                    check(hs_en == exp_hs(cur) && ls_en == exp_ls(cur) && ramp_start == rexp,
                          swap ? "R3 dead gap" : (rexp ? "R6 ramp" : "R2 decode"),
                          {3'b0, ramp_start, hs_en, ls_en}, {3'b0, rexp, exp_hs(cur), exp_ls(cur)});
                end
                check(leg_hiz == ~(exp_hs(t) | exp_ls(t)), "R2 leg_hiz",
                      {6'b0, leg_hiz}, {6'b0, ~(exp_hs(t) | exp_ls(t))});
            end
        end

        // R4/R5 sleep flag and wake pulse width
        settle(0, 3);
        check(sleep_o == 1'b1 && fault_n == 1'b1, "R4 idle sleep", {6'b0, sleep_o, fault_n}, 8'h03);
        set_cmd(2);
        for (int k = 1; k <= PULSE + 2; k++) begin
            tick();
            check(sleep_o == 1'b0, "R4 sleep exit", {7'b0, sleep_o}, 8'h00);
            check(fault_n == (k > PULSE), "R5 wake pulse", {7'b0, fault_n}, {7'b0, k > PULSE});
        end

        // R7 short overcurrent burst ignored, full burst latches
        ocp = 1'b1;
        repeat (OCPN - 1) tick();
        ocp = 1'b0;
        tick();
        expect_drive(2, "R7 short burst ignored");
        check(fault_n == 1'b1, "R7 short burst fault", {7'b0, fault_n}, 8'h01);
        ocp = 1'b1;
        repeat (OCPN - 1) tick();
        expect_drive(2, "R7 before threshold");
        tick();
        ocp = 1'b0;
        expect_drive(0, "R7 latched off");
        check(fault_n == 1'b0, "R7 latched fault", {7'b0, fault_n}, 8'h00);
        for (int m = 0; m < 4; m++) begin
            settle(m, DEAD + 2);
            expect_drive(0, "R7 held through commands");
            check(fault_n == 1'b0, "R7 held fault", {7'b0, fault_n}, 8'h00);
        end

        // R9 undervoltage clears the latch and resets state
        uvlo = 1'b1;
        tick();
        expect_drive(0, "R9 uvlo off");
        check(fault_n == 1'b0, "R9 uvlo fault", {7'b0, fault_n}, 8'h00);
        uvlo = 1'b0;
        set_cmd(3);
        tick();
        expect_drive(3, "R9 recovered brake");
        check(fault_n == 1'b0, "R9 wake pulse after uvlo", {7'b0, fault_n}, 8'h00);
        repeat (PULSE) tick();
        check(fault_n == 1'b1, "R9 fault clear", {7'b0, fault_n}, 8'h01);

        // R8 over-temperature blocks and auto-resumes
        settle(0, 3);
        settle(2, PULSE + 2);
        otemp = 1'b1;
        tick();
        expect_drive(0, "R8 otemp off");
        check(fault_n == 1'b0, "R8 otemp fault", {7'b0, fault_n}, 8'h00);
        repeat (3) tick();
        otemp = 1'b0;
        tick();
        expect_drive(2, "R8 resumed");
        check(ramp_start == 1'b1 && fault_n == 1'b1, "R8 resume ramp",
              {6'b0, ramp_start, fault_n}, 8'h03);

        // R10 current-limit persistence and self-clear
        ilim = 1'b1;
        repeat (ILIMN - 1) tick();
        check(fault_n == 1'b1, "R10 below threshold", {7'b0, fault_n}, 8'h01);
        tick();
        check(fault_n == 1'b0, "R10 fault asserted", {7'b0, fault_n}, 8'h00);
        expect_drive(2, "R10 bridge keeps running");
        ilim = 1'b0;
        tick();
        check(fault_n == 1'b1, "R10 self clear", {7'b0, fault_n}, 8'h01);

        // R11 idle clears the current-limit fault and its count
        ilim = 1'b1;
        repeat (ILIMN) tick();
        check(fault_n == 1'b0, "R11 fault before idle", {7'b0, fault_n}, 8'h00);
        set_cmd(0);
        tick();
        check(fault_n == 1'b1, "R11 cleared by idle", {7'b0, fault_n}, 8'h01);
        set_cmd(2);
        for (int k = 1; k <= ILIMN; k++) begin
            tick();
            if (k == PULSE + 2)
                check(fault_n == 1'b1, "R11 count restarted", {7'b0, fault_n}, 8'h01);
        end
        check(fault_n == 1'b0, "R11 refires after full count", {7'b0, fault_n}, 8'h00);
        ilim = 1'b0;
        tick();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule